// File: doc/BRIEF.md
# Desaturation Guard and Soft Turn-Off Sequencer

This block times one output channel of a power-switch gate driver. It takes a gate-on command, a desaturation comparator level that is already sampled to the clock domain, and a hold request from the phase-to-phase network. From these it drives four enables for the output stage: a main sourcing stage, a boost sourcing stage, a sinking stage and a soft turn-off pull-down. It also sends three signals to the fault manager.

When the channel turns on, the main sourcing stage stays enabled for the whole on-time. The boost stage is added only for a short first window, which shapes di/dt. After each turn-on the desaturation level is masked for a blanking window, because the switch is still coming out of its turn-on transient. After that window the level must stay high for a minimum number of consecutive cycles before it counts as a fault. A qualified fault starts a soft turn-off of fixed length. During it the source and sink stages float and only the pull-down is on. Gate commands and the hold request have no effect until the soft turn-off ends. The channel then stays off until the command has been seen low.

The controller has four states. OFF has the sink on. ON has the main source on, plus boost at the start. SOFT_OFF has only the pull-down on. REARM has the sink on and waits for the command to return low. The transitions are:
- turn_on: OFF to ON, command high and no hold.
- turn_off: ON to OFF, command low and no hold.
- trip: ON to SOFT_OFF, qualified desaturation. This takes priority over turn_off and over hold.
- expire: SOFT_OFF to REARM, at the end of the period.
- release: REARM to OFF, command low.

All durations are parameters counted in clock cycles.

Top module: `sds_sequencer`

## Requirements
- R1: While reset is asserted, the channel is in OFF. sink_en is 1 and every other output is 0.
- R2: Exactly one of sink_en, src_main_en and ssd_pull_en is 1 in every cycle. src_boost_en is 1 only when src_main_en is 1.
- R3: With hold_req low, a high gate_cmd sampled in OFF gives ON from the next cycle. src_boost_en is 1 for the first BOOST_CYC cycles of ON and then 0. src_main_en stays 1 as long as ON lasts.
- R4: With hold_req low, a low gate_cmd sampled in ON gives OFF (sink_en 1) from the next cycle, unless a trip happens in the same cycle.
- R5: During the first BLANK_CYC cycles of every ON period, desat_lvl is ignored. A high level that ends inside the window leaves the channel in ON.
- R6: After blanking, a trip needs desat_lvl sampled high in FILT_CYC consecutive cycles. A low sample restarts the count, so runs of up to FILT_CYC-1 cycles cause no trip. The trip takes effect in the cycle after the FILT_CYC-th high sample. If desat_lvl is high from turn-on, SOFT_OFF therefore begins BLANK_CYC+FILT_CYC cycles after ON begins.
- R7: desat_lvl has no effect in OFF or REARM. The outputs keep their OFF values and no soft turn-off starts.
- R8: SOFT_OFF lasts exactly SSD_CYC cycles. During it ssd_pull_en and ssd_active are 1 and the other stage enables are 0. ssd_start is 1 only in its first cycle and ssd_done only in its last cycle. gate_cmd and hold_req have no effect during it.
- R9: After SOFT_OFF the channel is in REARM with sink_en 1. It moves to OFF after a cycle in which gate_cmd is sampled low. Only after that can a new turn_on occur.
- R10: While hold_req is 1, gate_cmd does not change OFF or ON. Desaturation is still blanked, filtered and able to trip the channel into SOFT_OFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_cmd | input | 1 | Gate-on command, 1 = switch on |
| desat_lvl | input | 1 | Sampled desaturation comparator level, 1 = desaturated |
| hold_req | input | 1 | Freeze request, 1 = keep the current on/off state |
| src_main_en | output | 1 | Main sourcing stage enable |
| src_boost_en | output | 1 | Boost sourcing stage enable, first window of on-time only |
| sink_en | output | 1 | Sinking stage enable |
| ssd_pull_en | output | 1 | Soft turn-off pull-down enable |
| ssd_start | output | 1 | One-cycle pulse in the first cycle of a soft turn-off |
| ssd_active | output | 1 | High throughout a soft turn-off |
| ssd_done | output | 1 | One-cycle pulse in the last cycle of a soft turn-off |

## Verification
The bench builds the block with BOOST_CYC=4, BLANK_CYC=12, FILT_CYC=5 and SSD_CYC=20. These short windows put many full cycles of blanking, filtering and soft turn-off within a few thousand cycles of random stimulus. With them, directed cases can place desaturation runs exactly at FILT_CYC-1 and FILT_CYC. They can also end a high level on the last blanked cycle, and toggle the command in the final cycle of SOFT_OFF. Because the boost window is shorter than blanking, turn-offs that fall inside and outside the boost window are both reached.

// File: rtl/sds_pkg.sv
package sds_pkg;
    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_ON       = 2'd1,
        ST_SOFT_OFF = 2'd2,
        ST_REARM    = 2'd3
    } sds_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/sds_cycle_timer.sv
module sds_cycle_timer #(
    parameter int unsigned MAX_COUNT = 1000,
    localparam int unsigned W = $clog2(MAX_COUNT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LIMIT = W'(MAX_COUNT);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (count != LIMIT) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sds_desat_filter.sv
module sds_desat_filter #(
    parameter int unsigned FILT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic level,
    output logic qualified
);
    localparam int unsigned FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);
    localparam logic [FW-1:0] FULL = FW'(FILT_CYC);

    logic [FW-1:0] run_q;
    logic          sample_hi;

    assign sample_hi = armed && level;
    assign qualified = sample_hi && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !sample_hi) begin
            run_q <= '0;
        end else if (run_q != FULL) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/sds_sequencer.sv
module sds_sequencer
    import sds_pkg::*;
#(
    parameter int unsigned BOOST_CYC = 20,
    parameter int unsigned BLANK_CYC = 300,
    parameter int unsigned FILT_CYC  = 100,
    parameter int unsigned SSD_CYC   = 925
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_cmd,
    input  logic desat_lvl,
    input  logic hold_req,
    output logic src_main_en,
    output logic src_boost_en,
    output logic sink_en,
    output logic ssd_pull_en,
    output logic ssd_start,
    output logic ssd_active,
    output logic ssd_done
);
    localparam int unsigned CNT_MAX = max3(BOOST_CYC, BLANK_CYC, SSD_CYC);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] BOOST_L = CNT_W'(BOOST_CYC);
    localparam logic [CNT_W-1:0] BLANK_L = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] SSD_END = CNT_W'(SSD_CYC - 1);

    sds_state_e       state_q, state_d;
    logic [CNT_W-1:0] dwell;
    logic             blank_over;
    logic             trip;

    // Cycles spent in the present state; cleared on every state change.
    sds_cycle_timer #(.MAX_COUNT(CNT_MAX)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .count   (dwell)
    );

    assign blank_over = (state_q == ST_ON) && (dwell >= BLANK_L);

    sds_desat_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (blank_over),
        .level     (desat_lvl),
        .qualified (trip)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (!hold_req && gate_cmd) state_d = ST_ON;
            end
            ST_ON: begin
                if (trip)                        state_d = ST_SOFT_OFF;
                else if (!hold_req && !gate_cmd) state_d = ST_OFF;
            end
            ST_SOFT_OFF: begin
                if (dwell == SSD_END) state_d = ST_REARM;
            end
            ST_REARM: begin
                if (!gate_cmd) state_d = ST_OFF;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Output decode, one stage group per state.
    always_comb begin
        src_main_en  = 1'b0;
        src_boost_en = 1'b0;
        sink_en      = 1'b0;
        ssd_pull_en  = 1'b0;
        ssd_start    = 1'b0;
        ssd_active   = 1'b0;
        ssd_done     = 1'b0;
        unique case (state_q)
            ST_OFF, ST_REARM: sink_en = 1'b1;
            ST_ON: begin
                src_main_en  = 1'b1;
                src_boost_en = (dwell < BOOST_L);
            end
            ST_SOFT_OFF: begin
                ssd_pull_en = 1'b1;
                ssd_active  = 1'b1;
                ssd_start   = (dwell == '0);
                ssd_done    = (dwell == SSD_END);
            end
        endcase
    end
endmodule

// File: rtl/sds_sequencer_chk.sv
module sds_sequencer_chk #(
    parameter int unsigned BOOST_CYC = 20,
    parameter int unsigned BLANK_CYC = 300,
    parameter int unsigned FILT_CYC  = 100,
    parameter int unsigned SSD_CYC   = 925
) (
    input logic clk,
    input logic rst_n,
    input logic gate_cmd,
    input logic desat_lvl,
    input logic hold_req,
    input logic src_main_en,
    input logic src_boost_en,
    input logic sink_en,
    input logic ssd_pull_en,
    input logic ssd_start,
    input logic ssd_active,
    input logic ssd_done
);
    int unsigned boost_run;
    int unsigned pull_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boost_run <= 0;
            pull_run  <= 0;
        end else begin
            boost_run <= src_boost_en ? boost_run + 1 : 0;
            pull_run  <= ssd_pull_en  ? pull_run + 1  : 0;
        end
    end

    a_r2_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({sink_en, src_main_en, ssd_pull_en}));

    a_r2_boost_with_main: assert property (@(posedge clk) disable iff (!rst_n)
        src_boost_en |-> src_main_en);

    a_r3_boost_window: assert property (@(posedge clk) disable iff (!rst_n)
        boost_run < BOOST_CYC + 1);

    a_r8_soft_off_length: assert property (@(posedge clk) disable iff (!rst_n)
        pull_run < SSD_CYC + 1);

    a_r8_start_after_on: assert property (@(posedge clk) disable iff (!rst_n)
        ssd_start |-> $past(src_main_en));

    a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ssd_done |=> (!ssd_pull_en && sink_en));

    a_r7_no_trip_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        sink_en |=> !ssd_pull_en);
endmodule

bind sds_sequencer sds_sequencer_chk #(
    .BOOST_CYC (BOOST_CYC),
    .BLANK_CYC (BLANK_CYC),
    .FILT_CYC  (FILT_CYC),
    .SSD_CYC   (SSD_CYC)
) u_chk (.*);

// File: tb/sds_sequencer_test.sv
module sds_sequencer_test;
    localparam int BOOST = 4;
    localparam int BLANK = 12;
    localparam int FILT  = 5;
    localparam int SSD   = 20;
    localparam int CMAX  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_cmd = 1'b0, desat_lvl = 1'b0, hold_req = 1'b0;
    logic src_main_en, src_boost_en, sink_en, ssd_pull_en;
    logic ssd_start, ssd_active, ssd_done;

    always #5 clk = ~clk;

    sds_sequencer #(.BOOST_CYC(BOOST), .BLANK_CYC(BLANK), .FILT_CYC(FILT), .SSD_CYC(SSD)) uut (
        .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd), .desat_lvl(desat_lvl),
        .hold_req(hold_req), .src_main_en(src_main_en), .src_boost_en(src_boost_en),
        .sink_en(sink_en), .ssd_pull_en(ssd_pull_en), .ssd_start(ssd_start),
        .ssd_active(ssd_active), .ssd_done(ssd_done));

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    string req = "R1";

    // Reference model: 0 off, 1 on, 2 soft off, 3 rearm.
    int m_st = 0, m_cnt = 0, m_run = 0;

    function automatic logic [6:0] expect_out(int st, int cnt);
        logic [6:0] v;
        v = '0;
        case (st)
            1: v = {1'b1, (cnt < BOOST), 5'b00000};
            2: v = {2'b00, 1'b0, 1'b1, 1'b1, (cnt == 0), (cnt == SSD - 1)};
            default: v = 7'b0010000;
        endcase
        return v;
    endfunction

    task automatic model_step(input logic g, input logic d, input logic h);
        int ns;
        bit armed, trip;
        ns = m_st;
        armed = (m_st == 1) && (m_cnt >= BLANK);
        trip = armed && d && (m_run == FILT - 1);
        case (m_st)
            0: if (!h && g) ns = 1;
            1: if (trip) ns = 2; else if (!h && !g) ns = 0;
            2: if (m_cnt == SSD - 1) ns = 3;
            default: if (!g) ns = 0;
        endcase
        m_run = (armed && d) ? ((m_run < FILT) ? m_run + 1 : FILT) : 0;
        m_cnt = (ns != m_st) ? 0 : ((m_cnt < CMAX) ? m_cnt + 1 : CMAX);
        m_st  = ns;
    endtask

    task automatic compare(input logic [6:0] exp, input string tag);
        logic [6:0] act;
        act = {src_main_en, src_boost_en, sink_en, ssd_pull_en, ssd_active, ssd_start, ssd_done};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: outputs actual %b expected %b (state %0d cnt %0d)",
                     tag, act, exp, m_st, m_cnt);
        end
    endtask

    // One cycle: check at the falling edge, then drive the next inputs.
    task automatic step(input logic g, input logic d, input logic h);
        @(negedge clk);
        compare(expect_out(m_st, m_cnt), req);
        gate_cmd = g; desat_lvl = d; hold_req = h;
        model_step(g, d, h);
    endtask

    task automatic go_off();
        step(0, 0, 0);
        step(0, 0, 0);
    endtask

    initial begin
        logic g, d, h;
        void'($urandom(32'h1357_2468));
        // R1: reset state
        req = "R1";
        repeat (3) begin
            @(negedge clk);
            compare(7'b0010000, "R1");
        end
        rst_n = 1'b1;
        m_st = 0; m_cnt = 0; m_run = 0;

        // R3, R4: turn on, boost window, turn off inside and after boost
        req = "R3";
        for (int i = 0; i < BLANK + 3; i++) step(1, 0, 0);
        req = "R4";
        go_off();
        step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);

        // R5: high level ending on the last blanked cycle
        req = "R5";
        for (int i = 0; i < BLANK + 1; i++) step(1, (i >= 1), 0);
        for (int i = 0; i < 8; i++) step(1, 0, 0);
        go_off();

        // R6: runs of FILT-1 cause no trip, FILT does
        req = "R6";
        for (int i = 0; i < BLANK + 2; i++) step(1, 0, 0);
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < FILT - 1; i++) step(1, 1, 0);
            step(1, 0, 0);
        end
        for (int i = 0; i < FILT + 2; i++) step(1, 1, 0);
        // R8: soft off with command and hold toggling
        req = "R8";
        for (int i = 0; i < SSD; i++) step(i[0], 1, i[1]);
        // R9: rearm waits for command low
        req = "R9";
        for (int i = 0; i < 4; i++) step(1, 0, 0);
        step(0, 0, 0); step(1, 0, 0); step(1, 0, 0);
        go_off();

        // R6: level high from turn-on trips at BLANK+FILT
        req = "R6";
        for (int i = 0; i < BLANK + FILT + 3; i++) step(1, 1, 0);
        for (int i = 0; i < SSD; i++) step(0, 0, 0);
        go_off();

        // R7: desaturation while off
        req = "R7";
        for (int i = 0; i < BLANK + FILT + 10; i++) step(0, 1, 0);

        // R10: hold freezes on and off, trips still happen
        req = "R10";
        for (int i = 0; i < 6; i++) step(1, 0, 1);
        step(0, 0, 0); step(1, 0, 0);
        for (int i = 0; i < BLANK + 2; i++) step(0, 0, 1);
        for (int i = 0; i < FILT + 2; i++) step(0, 1, 1);
        for (int i = 0; i < SSD + 2; i++) step(0, 0, 1);
        go_off();

        // R2: random mix
        req = "R2";
        g = 0; d = 0; h = 0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 24) == 0) g = ~g;
            if ($urandom_range(0, 7) == 0)  d = ~d;
            if ($urandom_range(0, 59) == 0) h = ~h;
            step(g, d, h);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run actual unfinished, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule